// File: doc/BRIEF.md
# Run-Time Width Serial Deserializer with Training Lock

This block turns a one-bit serial stream, clocked in at the bit rate, into parallel words of 8, 10 or 12 bits. The width is picked at run time by a two-bit select. Bits arrive most significant first. A word strobe pulses once for every completed word. Every output is produced in the bit clock domain. At 600 Mbit/s this gives 75, 60 or 50 million words per second.

To find the word boundary, the sender transmits a fixed training word while it is idle. For 12 bits this word is 0xBAF. The narrower modes use its leading bits, which give 0x2EB for 10 bits and 0xBA for 8 bits. When training is enabled, an alignment controller compares each finished word with that pattern. On a mismatch, it delays the bit counter by one bit position and then lets a few words pass before it compares again. After a run of consecutive matches it raises an aligned flag. That flag stays up until the width select changes or reset is applied.

Top module: `serial_deser`

## Requirements
- R1: The width select decodes as 00 = 8 bits, 01 = 10 bits, 10 = 12 bits, and 11 = 12 bits.
- R2: A word is assembled most significant bit first from consecutive serial bits. `wordValid` pulses for one cycle every W bit clocks, and the word occupies bits W-1..0 of `wordOut`, with the upper bits zero.
- R3: The training pattern is 0xBAF in 12-bit mode, 0x2EB in 10-bit mode and 0xBA in 8-bit mode.
- R4: While training and not aligned, a word that differs from the pattern causes exactly one single-bit slip of the word boundary. The next 4 words are then ignored before comparison resumes, so lock is reached from any starting bit offset.
- R5: `aligned` rises after 8 consecutive matching words while training is enabled. Once aligned, the words that follow equal the training pattern.
- R6: `aligned` clears in the cycle after the width select changes. Otherwise it stays set, including while non-pattern data flows.
- R7: With training disabled, no slip occurs and `aligned` never rises, so the word framing stays constant.
- R8: After lock, data words sent by the transmitter appear on `wordOut` in order and with correct framing.
- R9: After reset, `aligned` and `wordValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| serialIn | input | 1 | Serial data, one bit per clock, MSB first |
| widthSel | input | 2 | Word width select (00=8, 01=10, 1x=12) |
| trainEn | input | 1 | Enables the bitslip search against the training pattern |
| wordOut | output | 12 | Assembled word, right-justified |
| wordValid | output | 1 | One-cycle strobe per completed word |
| aligned | output | 1 | Word boundary locked to the training pattern |

## Verification
The bench starts the training stream at several bit offsets in every width, including select 11. A controller that slipped more than once per mismatch, or compared before a slip had taken effect, would oscillate and never lock. After lock, a stream of counting data words is checked. A framing that was off by a bit would shift the values, and dropping or duplicating a word would break the sequence. A width change must clear the flag at once. With training off, a misaligned stream must keep one constant rotation, which exposes any slip that fires without training.

// File: rtl/deser_pkg.sv
package deser_pkg;
  localparam int MAX_W = 12;
  localparam logic [MAX_W-1:0] FULL_PATTERN = 12'hBAF;

  typedef struct packed {
    logic slip;
    logic restart;
  } deserCtrl_t;

  function automatic logic [3:0] widthOf(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd8;
      2'b01:   return 4'd10;
      default: return 4'd12;
    endcase
  endfunction

  function automatic logic [MAX_W-1:0] trainPattern(input logic [1:0] sel);
    return FULL_PATTERN >> (4'd12 - widthOf(sel));
  endfunction
endpackage

// File: rtl/deser_datapath.sv
module deser_datapath
  import deser_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             serialIn,
  input  logic [1:0]       widthSel,
  input  deserCtrl_t       ctrl,
  output logic [MAX_W-1:0] word,
  output logic             wordValid
);
  logic [MAX_W-1:0] shiftQ;
  logic [MAX_W-1:0] assembled;
  logic [MAX_W-1:0] widthMask;
  logic [3:0]       bitCnt;
  logic [3:0]       curW;
  logic             lastBit;
  logic             wordDone;

  always_comb begin
    curW      = widthOf(widthSel);
    assembled = {shiftQ[MAX_W-2:0], serialIn};
    widthMask = (12'd1 << curW) - 12'd1;
    lastBit   = (bitCnt >= curW - 4'd1);
    wordDone  = lastBit && !ctrl.slip && !ctrl.restart;
  end

  always_ff @(posedge clk) begin
    shiftQ <= assembled;
    if (rst) begin
      bitCnt    <= '0;
      word      <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= wordDone;
      if (wordDone) word <= assembled & widthMask;
      if (ctrl.restart)   bitCnt <= '0;
      else if (ctrl.slip) bitCnt <= bitCnt;
      else if (lastBit)   bitCnt <= '0;
      else                bitCnt <= bitCnt + 4'd1;
    end
  end
endmodule

// File: rtl/deser_ctrl.sv
module deser_ctrl
  import deser_pkg::*;
#(
  parameter int SETTLE_WORDS = 4,
  parameter int LOCK_WORDS   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       widthSel,
  input  logic             trainEn,
  input  logic [MAX_W-1:0] word,
  input  logic             wordValid,
  output deserCtrl_t       ctrl,
  output logic             aligned
);
  localparam int SW = $clog2(SETTLE_WORDS + 1);
  localparam int MW = $clog2(LOCK_WORDS + 1);

  logic [1:0]    widthQ;
  logic [SW-1:0] settleCnt;
  logic [MW-1:0] matchCnt;
  logic          slipQ;
  logic          widthChg;
  logic          isMatch;

  always_comb begin
    widthChg     = (widthSel != widthQ);
    isMatch      = (word == trainPattern(widthSel));
    ctrl.slip    = slipQ;
    ctrl.restart = widthChg;
  end

  always_ff @(posedge clk) begin
    widthQ <= widthSel;
    if (rst) begin
      aligned   <= 1'b0;
      settleCnt <= '0;
      matchCnt  <= '0;
      slipQ     <= 1'b0;
    end else begin
      slipQ <= 1'b0;
      if (widthChg) begin
        aligned   <= 1'b0;
        settleCnt <= '0;
        matchCnt  <= '0;
      end else if (wordValid && trainEn && !aligned) begin
        if (settleCnt != '0) begin
          settleCnt <= settleCnt - 1'b1;
        end else if (isMatch) begin
          if (matchCnt == MW'(LOCK_WORDS - 1)) aligned <= 1'b1;
          else matchCnt <= matchCnt + 1'b1;
        end else begin
          slipQ     <= 1'b1;
          matchCnt  <= '0;
          settleCnt <= SW'(SETTLE_WORDS);
        end
      end
    end
  end
endmodule

// File: rtl/serial_deser.sv
module serial_deser
  import deser_pkg::*;
#(
  parameter int SETTLE_WORDS = 4,
  parameter int LOCK_WORDS   = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        serialIn,
  input  logic [1:0]  widthSel,
  input  logic        trainEn,
  output logic [11:0] wordOut,
  output logic        wordValid,
  output logic        aligned
);
  deserCtrl_t       ctrl;
  logic [MAX_W-1:0] word;

  deser_datapath dp_i (
    .clk(clk), .rst(rst), .serialIn(serialIn), .widthSel(widthSel),
    .ctrl(ctrl), .word(word), .wordValid(wordValid)
  );

  deser_ctrl #(.SETTLE_WORDS(SETTLE_WORDS), .LOCK_WORDS(LOCK_WORDS)) ctrl_i (
    .clk(clk), .rst(rst), .widthSel(widthSel), .trainEn(trainEn),
    .word(word), .wordValid(wordValid), .ctrl(ctrl), .aligned(aligned)
  );

  assign wordOut = word;
endmodule

// File: rtl/serial_deser_chk.sv
module serial_deser_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] widthSel,
  input logic       trainEn,
  input logic       wordValid,
  input logic       aligned
);
  // R2
  valid_gap_chk: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid);

  // R6
  aligned_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(widthSel) |=> !aligned);

  // R6
  aligned_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (aligned && $stable(widthSel)) |=> aligned);

  // R7
  lock_needs_train_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned) |-> $past(trainEn));
endmodule

bind serial_deser serial_deser_chk chk_i (
  .clk(clk), .rst(rst), .widthSel(widthSel), .trainEn(trainEn),
  .wordValid(wordValid), .aligned(aligned)
);

// File: tb/serial_deser_tb_top.sv
module serial_deser_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        serialIn;
  logic [1:0]  widthSel;
  logic        trainEn;
  logic [11:0] wordOut;
  logic        wordValid;
  logic        aligned;

  int checks = 0;
  int errors = 0;

  int          txW = 12;
  bit          txMode = 1'b0;
  int          txData = 0;
  int          txBit = 0;
  int          txHold = 0;
  logic [11:0] txWord = 12'hBAF;

  always #4 clk = ~clk;

  serial_deser dut_i (
    .clk(clk), .rst(rst), .serialIn(serialIn), .widthSel(widthSel),
    .trainEn(trainEn), .wordOut(wordOut), .wordValid(wordValid), .aligned(aligned)
  );

  function automatic logic [11:0] expPat(int w);
    return 12'hBAF >> (12 - w);
  endfunction

  function automatic int selWidth(logic [1:0] s);
    return (s == 2'b00) ? 8 : (s == 2'b01) ? 10 : 12;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // transmitter: one bit per clock, MSB first; txHold repeats a bit to shift framing
  initial begin
    serialIn = 1'b0;
    forever begin
      @(negedge clk);
      if (txHold > 0) txHold--;
      else begin
        if (txBit >= txW) txBit = 0;
        serialIn = txWord[txW-1-txBit];
        txBit++;
        if (txBit >= txW) begin
          txBit = 0;
          if (txMode) begin
            txData++;
            txWord = 12'(txData) & 12'((1 << txW) - 1);
          end else txWord = expPat(txW);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic waitValid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (wordValid) begin got = 1'b1; break; end
    end
  endtask

  task automatic startPattern(logic [1:0] sel, int slips);
    widthSel = sel;
    txW = selWidth(sel);
    txMode = 1'b0;
    txWord = expPat(txW);
    txBit = 0;
    txHold = slips;
  endtask

  // R9
  task automatic testReset();
    rst = 1'b1; trainEn = 1'b0; widthSel = 2'b10;
    repeat (4) @(negedge clk);
    check(!aligned, "R9 aligned after reset", aligned, 0);
    check(!wordValid, "R9 wordValid after reset", wordValid, 0);
    rst = 1'b0;
  endtask

  // R1 R3 R4 R5
  task automatic testLock(logic [1:0] sel, int slips, string tag);
    bit done = 1'b0;
    bit got;
    int w = selWidth(sel);
    startPattern(sel, slips);
    trainEn = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (aligned) begin done = 1'b1; break; end
    end
    check(done, {"R4 R5 lock reached ", tag}, aligned, 1);
    for (int k = 0; k < 4; k++) begin
      waitValid(got);
      check(got && wordOut == expPat(w), {"R1 R3 pattern after lock ", tag},
            wordOut, expPat(w));
    end
  endtask

  // R2 R6 R8
  task automatic testData(string tag);
    bit got;
    int first = 0;
    int t0;
    int gap;
    int w = txW;
    txData = 0;
    txMode = 1'b1;
    for (int i = 0; i < 40; i++) begin
      waitValid(got);
      if (got && wordOut != expPat(w)) begin first = wordOut; break; end
    end
    check(first == 1, {"R8 first data word ", tag}, first, 1);
    for (int k = 2; k < 10; k++) begin
      waitValid(got);
      check(got && wordOut == 12'(k), {"R8 data order ", tag}, wordOut, k);
    end
    t0 = 0;
    waitValid(got);
    for (int i = 1; i < 100; i++) begin
      @(negedge clk);
      if (wordValid) begin t0 = i; break; end
    end
    gap = t0;
    check(gap == w, {"R2 word spacing ", tag}, gap, w);
    check(aligned, {"R6 aligned held during data ", tag}, aligned, 1);
    txMode = 1'b0;
    txWord = expPat(w);
  endtask

  // R6
  task automatic testWidthChange(logic [1:0] sel);
    widthSel = sel;
    @(negedge clk);
    check(!aligned, "R6 aligned cleared on width change", aligned, 0);
  endtask

  // R7
  task automatic testNoTrain();
    bit got;
    logic [11:0] ref0;
    bit same = 1'b1;
    rst = 1'b1; trainEn = 1'b0;
    startPattern(2'b01, 3);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) waitValid(got);
    ref0 = wordOut;
    for (int k = 0; k < 40; k++) begin
      waitValid(got);
      if (wordOut != ref0) same = 1'b0;
      if (aligned) same = 1'b0;
    end
    check(same, "R7 framing constant without training", wordOut, ref0);
    check(!aligned, "R7 no lock without training", aligned, 0);
  endtask

  initial begin
    testReset();
    testLock(2'b10, 3, "w12");
    testData("w12");
    testWidthChange(2'b01);
    testLock(2'b01, 5, "w10");
    testData("w10");
    testWidthChange(2'b00);
    testLock(2'b00, 6, "w8");
    testData("w8");
    testWidthChange(2'b11);
    testLock(2'b11, 7, "sel11");
    testData("sel11");
    testNoTrain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule